// File: doc/BRIEF.md
# Baud-Framed Control Word Receiver

This block sits on the device side of a six-wire serial link. It receives the transmit-direction control word. Two clocks arrive from the host processor: a symbol-rate frame clock, and a continuous bit clock that runs 48 times faster. Everything in the block runs on the bit clock. The frame clock is treated as a sampled data input.

When the frame clock goes from low to high, a new symbol period starts. The block then shifts in a 16-bit word, most significant bit first, over the first 16 bit clocks of that period. It ignores the serial line for the remaining 32 bit clocks. Once the last bit is in, the word is decoded into registered outputs:
- a signed four-level line symbol, with a one-cycle valid strobe;
- a receive gain code;
- a loopback select;
- a transmit power boost select.

Two sticky flags report faults. One is raised when the host asks for a gain code outside the legal set. The other is raised when the frame clock does not recur exactly one symbol period after the previous frame start.

Top module: `baud_word_rx`

## Requirements
- R1: A frame starts on the first rising bit-clock edge at which `baud_i` is sampled high after having been sampled low. That edge samples word bit 15 from `sdata_i`. The next 15 edges sample bits 14 down to 0 in that order.
- R2: Values on `sdata_i` at the bit-clock edges 16 to 47 of a frame have no effect on any output.
- R3: The outputs for a word change on the bit-clock edge after the edge that sampled bit 0, and not earlier. At that same edge `sym_valid_o` rises for exactly one cycle, once per received word.
- R4: When word bit 15 is 0, `sym_o` becomes 0, whatever bits 14:13 hold.
- R5: When bit 15 is 1, bits 14:13 select `sym_o`, which is 3-bit two's complement: 00 gives -3 (3'b101), 01 gives -1 (3'b111), 11 gives +1 (3'b001), 10 gives +3 (3'b011).
- R6: Bits 12:10 hold a gain code. Values 0 to 4 (0, 3, 6, 9 and 12 dB) are copied to `gain_o`.
- R7: A gain code of 5, 6 or 7 leaves `gain_o` at its previous value and sets `gain_err_o`. The flag stays set until reset.
- R8: Bit 9 drives `loopback_o` and bit 8 drives `boost_o`. Bits 7:0 have no effect on any output.
- R9: If `baud_i` rises at any point other than exactly 48 bit clocks after the previous frame start, `frame_err_o` is set and stays set. The new edge starts a new frame, and that word is received normally.
- R10: If no rising edge of `baud_i` appears 48 bit clocks after a frame start, `frame_err_o` is set. No word is decoded until the next rising edge of `baud_i`, which restarts framing.
- R11: After reset the outputs read as follows: `sym_o` is 0, `sym_valid_o` is 0, `gain_o` is 0, `loopback_o` is 0, `boost_o` is 0, and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, 48 periods per symbol |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_i | input | 1 | Symbol-rate frame clock, sampled on clk_i |
| sdata_i | input | 1 | Serial control word, MSB first |
| sym_o | output | 3 | Signed symbol level |
| sym_valid_o | output | 1 | One-cycle strobe when a new word is applied |
| gain_o | output | 3 | Applied receive gain code |
| loopback_o | output | 1 | Loopback select |
| boost_o | output | 1 | Transmit power boost select |
| gain_err_o | output | 1 | Sticky flag: a reserved gain code was received |
| frame_err_o | output | 1 | Sticky flag: the frame clock was off period or missing |

## Verification
The hardest cases to reach are the two framing faults. A correct host never produces them, and both flags are sticky, so each fault needs its own reset window.

The stimulus builds frames of programmable length, and can suppress the frame-clock edge entirely:
- A 40-clock frame followed by a normal frame makes the frame clock rise early. The check is that the following word still decodes.
- A 48-clock frame with the frame clock held low removes the expected edge. The check is that no strobe appears until a later frame relocks.

Random words fill the tail bits and spare bits with noise, which shows that neither can leak into the outputs.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  // field positions decoded from the control word
  localparam int unsigned EN_POS    = 15;
  localparam int unsigned SYM_HI    = 14;
  localparam int unsigned SYM_LO    = 13;
  localparam int unsigned GAIN_HI   = 12;
  localparam int unsigned GAIN_LO   = 10;
  localparam int unsigned LOOP_POS  = 9;
  localparam int unsigned BOOST_POS = 8;

  typedef enum logic [1:0] {
    SYM_M3 = 2'b00,
    SYM_M1 = 2'b01,
    SYM_P3 = 2'b10,
    SYM_P1 = 2'b11
  } sym_code_e;

  function automatic logic signed [2:0] sym_level(input logic [1:0] code);
    logic signed [2:0] lvl;
    case (sym_code_e'(code))
      SYM_M3:  lvl = -3'sd3;
      SYM_M1:  lvl = -3'sd1;
      SYM_P1:  lvl = 3'sd1;
      default: lvl = 3'sd3;
    endcase
    return lvl;
  endfunction
endpackage

// File: rtl/bwr_frame.sv
module bwr_frame #(
  parameter int FRAME_LEN = 48,
  parameter int WORD_W    = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic baud_i,
  output logic shift_o,
  output logic last_o,
  output logic frame_err_o
);
  localparam int CW = $clog2(FRAME_LEN);
  localparam logic [CW-1:0] CNT_MAX  = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] WORD_END = CW'(WORD_W - 1);
  localparam logic [CW-1:0] WORD_LEN = CW'(WORD_W);

  logic          baud_q;
  logic          locked_q;
  logic [CW-1:0] cnt_q;
  logic          rise_w;

  assign rise_w = baud_i & ~baud_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      baud_q      <= 1'b0;
      locked_q    <= 1'b0;
      cnt_q       <= '0;
      frame_err_o <= 1'b0;
    end else begin
      baud_q <= baud_i;
      if (rise_w) begin
        // new frame: this edge carries bit 0 of the period
        if (locked_q && cnt_q != '0) frame_err_o <= 1'b1;
        locked_q <= 1'b1;
        cnt_q    <= CW'(1);
      end else if (locked_q) begin
        if (cnt_q == '0) begin
          // expected edge missing
          frame_err_o <= 1'b1;
          locked_q    <= 1'b0;
        end else begin
          cnt_q <= (cnt_q == CNT_MAX) ? '0 : cnt_q + CW'(1);
        end
      end
    end
  end

  assign shift_o = rise_w | (locked_q && cnt_q != '0 && cnt_q < WORD_LEN);
  assign last_o  = ~rise_w & locked_q & (cnt_q == WORD_END);

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  // R1
  start_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_w |=> (locked_q && cnt_q == CW'(1)));
  // R9
  frame_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> frame_err_o);
  // R10
  unlock_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_q) |-> frame_err_o);
endmodule

// File: rtl/bwr_shift.sv
module bwr_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              shift_i,
  input  logic              last_i,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      done_o <= 1'b0;
    end else begin
      if (shift_i) word_o <= {word_o[WORD_W-2:0], sdata_i};
      done_o <= last_i & shift_i;
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(word_o));
endmodule

// File: rtl/bwr_decode.sv
module bwr_decode
  import bwr_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int GAIN_W   = 3,
  parameter int GAIN_MAX = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [WORD_W-1:0]   word_i,
  input  logic                done_i,
  output logic signed [2:0]   sym_o,
  output logic                sym_valid_o,
  output logic [GAIN_W-1:0]   gain_o,
  output logic                loopback_o,
  output logic                boost_o,
  output logic                gain_err_o
);
  logic [GAIN_W-1:0] gain_code_w;
  logic              gain_ok_w;
  logic signed [2:0] sym_w;
  logic [7:0]        unused_spare;

  assign gain_code_w  = word_i[GAIN_HI:GAIN_LO];
  assign gain_ok_w    = gain_code_w <= GAIN_W'(GAIN_MAX);
  assign sym_w        = word_i[EN_POS] ? sym_level(word_i[SYM_HI:SYM_LO]) : 3'sd0;
  assign unused_spare = word_i[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_o       <= '0;
      sym_valid_o <= 1'b0;
      gain_o      <= '0;
      loopback_o  <= 1'b0;
      boost_o     <= 1'b0;
      gain_err_o  <= 1'b0;
    end else begin
      sym_valid_o <= done_i;
      if (done_i) begin
        sym_o      <= sym_w;
        loopback_o <= word_i[LOOP_POS];
        boost_o    <= word_i[BOOST_POS];
        if (gain_ok_w) gain_o     <= gain_code_w;
        else           gain_err_o <= 1'b1;
      end
    end
  end

  // R6
  gain_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_o <= GAIN_W'(GAIN_MAX));
  // R7
  gain_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_err_o |=> gain_err_o);
  // R5
  sym_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_o != -3'sd4 && sym_o != 3'sd2 && sym_o != -3'sd2);
  // R3
  sym_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> ($stable(sym_o) && $stable(gain_o) && !sym_valid_o));
endmodule

// File: rtl/baud_word_rx.sv
module baud_word_rx #(
  parameter int FRAME_LEN = 48,
  parameter int WORD_W    = 16,
  parameter int GAIN_W    = 3,
  parameter int GAIN_MAX  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_i,
  input  logic              sdata_i,
  output logic signed [2:0] sym_o,
  output logic              sym_valid_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic              loopback_o,
  output logic              boost_o,
  output logic              gain_err_o,
  output logic              frame_err_o
);
  logic              shift_w;
  logic              last_w;
  logic              done_w;
  logic [WORD_W-1:0] word_w;

  bwr_frame #(.FRAME_LEN(FRAME_LEN), .WORD_W(WORD_W)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .baud_i      (baud_i),
    .shift_o     (shift_w),
    .last_o      (last_w),
    .frame_err_o (frame_err_o)
  );

  bwr_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sdata_i (sdata_i),
    .shift_i (shift_w),
    .last_i  (last_w),
    .word_o  (word_w),
    .done_o  (done_w)
  );

  bwr_decode #(.WORD_W(WORD_W), .GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)) u_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_i      (word_w),
    .done_i      (done_w),
    .sym_o       (sym_o),
    .sym_valid_o (sym_valid_o),
    .gain_o      (gain_o),
    .loopback_o  (loopback_o),
    .boost_o     (boost_o),
    .gain_err_o  (gain_err_o)
  );
endmodule

// File: tb/sim_baud_word_rx.sv
module sim_baud_word_rx;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic baud_i = 1'b0;
  logic sdata_i = 1'b0;
  logic [2:0] sym_o;
  logic sym_valid_o, loopback_o, boost_o, gain_err_o, frame_err_o;
  logic [2:0] gain_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [2:0] e_sym;
  logic [2:0] e_gain;
  logic e_lb, e_bst, e_gerr, e_ferr;

  baud_word_rx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .baud_i(baud_i), .sdata_i(sdata_i),
    .sym_o(sym_o), .sym_valid_o(sym_valid_o), .gain_o(gain_o),
    .loopback_o(loopback_o), .boost_o(boost_o),
    .gain_err_o(gain_err_o), .frame_err_o(frame_err_o)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, cycles %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [2:0] exp_level(input logic [15:0] w);
    if (!w[15]) return 3'b000;
    case (w[14:13])
      2'b00:   return 3'b101;
      2'b01:   return 3'b111;
      2'b11:   return 3'b001;
      default: return 3'b011;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_word(input logic [15:0] w);
    e_sym = exp_level(w);
    if (w[12:10] <= 3'd4) e_gain = w[12:10];
    else e_gerr = 1'b1;
    e_lb  = w[9];
    e_bst = w[8];
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    baud_i = 1'b0;
    sdata_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    e_sym = 0; e_gain = 0; e_lb = 0; e_bst = 0; e_gerr = 0; e_ferr = 0;
  endtask

  task automatic send_frame(input logic [15:0] w, input int len, input bit baud_on,
                            output int vcnt, output logic [2:0] sym16, output logic v17);
    vcnt = 0;
    sym16 = 3'bxxx;
    v17 = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 16) sym16 = sym_o;
      if (i == 17) v17 = sym_valid_o;
      if (sym_valid_o) vcnt++;
      baud_i  = baud_on && (i < len / 2);
      sdata_i = (i < 16) ? w[15-i] : 1'($urandom);
    end
  endtask

  task automatic check_outputs(input string tag);
    chk(sym_o == e_sym, {tag, " sym"}, sym_o, e_sym);
    chk(gain_o == e_gain, {tag, " gain"}, gain_o, e_gain);
    chk(loopback_o == e_lb, {tag, " loopback"}, loopback_o, e_lb);
    chk(boost_o == e_bst, {tag, " boost"}, boost_o, e_bst);
    chk(gain_err_o == e_gerr, {tag, " gain_err"}, gain_err_o, e_gerr);
    chk(frame_err_o == e_ferr, {tag, " frame_err"}, frame_err_o, e_ferr);
  endtask

  task automatic good_word(input logic [15:0] w, input string tag);
    int vc;
    logic [2:0] s16, old_sym;
    logic v17;
    old_sym = e_sym;
    send_frame(w, 48, 1'b1, vc, s16, v17);
    // R3: nothing applied before the LSB edge, one strobe per word
    chk(s16 == old_sym, {tag, " R3 early update"}, s16, old_sym);
    chk(v17 == 1'b1, {tag, " R3 strobe timing"}, v17, 1);
    chk(vc == 1, {tag, " R3 strobe count"}, vc, 1);
    model_word(w);
    check_outputs(tag);
  endtask

  initial begin
    int vc;
    logic [2:0] s16;
    logic v17;
    logic [15:0] w;
    void'($urandom(32'h5eed));
    do_reset();
    @(negedge clk);
    // R11
    chk(sym_valid_o == 1'b0, "R11 reset valid", sym_valid_o, 0);
    check_outputs("R11 reset");

    // R1 R5 R6 R8: directed words, one per symbol code
    good_word(16'b1_00_010_1_0_10101010, "R5 R6 R8 sym -3");
    good_word(16'b1_01_100_0_1_01010101, "R5 R6 R8 sym -1");
    good_word(16'b1_11_000_1_1_11111111, "R5 R1 sym +1");
    good_word(16'b1_10_011_0_0_00000000, "R5 R1 sym +3");
    // R4: enable low masks symbol bits
    good_word(16'b0_10_001_1_0_11001100, "R4 enable low");
    good_word(16'b0_00_001_0_1_00110011, "R4 enable low 2");
    // R8: spare bits differ only, outputs unchanged
    good_word(16'b0_00_001_0_1_11001100, "R8 spare ignored");
    // R7: reserved gain code holds gain
    good_word(16'b1_01_101_0_0_00000000, "R7 reserved 5");
    good_word(16'b1_11_111_1_0_00000000, "R7 reserved 7");
    good_word(16'b1_11_100_1_0_00000000, "R6 legal after reserved");

    // R2: random words with random tails and spares
    for (int k = 0; k < 40; k++) begin
      w = 16'($urandom);
      good_word(w, "R2 random");
    end

    // R9: early frame-clock edge
    do_reset();
    good_word(16'b1_00_001_0_0_00000000, "R9 pre");
    send_frame(16'b1_10_010_1_1_00000000, 40, 1'b1, vc, s16, v17);
    model_word(16'b1_10_010_1_1_00000000);
    chk(frame_err_o == 1'b0, "R9 no error before edge", frame_err_o, 0);
    e_ferr = 1'b1;
    good_word(16'b1_01_011_0_1_00000000, "R9 realigned word");

    // R10: missing frame-clock edge
    do_reset();
    good_word(16'b1_11_010_0_0_00000000, "R10 pre");
    send_frame(16'b1_00_100_1_1_00000000, 48, 1'b0, vc, s16, v17);
    e_ferr = 1'b1;
    chk(vc == 0, "R10 no strobe without edge", vc, 0);
    check_outputs("R10 held");
    good_word(16'b1_10_001_1_0_00000000, "R10 relock");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule